// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the control end of a serial test port. A four-wire serial interface (test clock, mode select, serial data in, serial data out) plus an active-low asynchronous reset steps a sixteen-state controller. The controller holds a 10-bit instruction and decodes it to pick one of three data paths between serial input and serial output: a one-bit pass-through register, a 32-bit identification register, or an external boundary register. The boundary register sits outside the block and its serial output comes back in on an input.

Mode select is sampled on the rising test-clock edge. Serial data is taken in on the rising edge and driven out on the falling edge. The serial output has a separate enable that is high only while a shift is in progress. For the external boundary register the block provides capture, shift and update strobes, plus two pin controls. One makes the pins follow the boundary update flops. The other floats the pins.

The identification register loads a fixed code built from version, part and manufacturer parameters, with the least significant bit forced to 1. Under the user-code instruction it instead loads a 32-bit value from an input port.

Top module: `scan_port_top`

## Requirements
- R1: Driving testRstN low resets the controller at once, with no clock edge: scanOutEn goes low immediately, and the instruction reverts to the identification code.
- R2: Five consecutive rising edges with modeSel high bring the controller to the reset state from any state, and it stays there while modeSel remains high.
- R3: In the reset state the active instruction is 0x006. A data scan begun straight after reset returns {version[3:0], part[15:0], manufacturer[10:0], 1'b1}, least significant bit first.
- R4: From reset, the modeSel sequence 0,1,1,0,0 reaches the instruction-shift state. scanOutEn rises on the first falling edge after a shift state is entered, falls on the first falling edge after it is left, and is low in every other state.
- R5: The capture-instruction state loads 0x001, so the first two bits shifted out are 1 then 0 and the remaining eight are 0.
- R6: Instructions are 10 bits, shifted least significant bit first. They select data paths as follows: 0x006 and 0x007 select the 32-bit identification register; 0x005 and 0x00F select the boundary register; 0x3FF, 0x00A, 0x00B and every code not listed here select the one-bit pass-through register.
- R7: The pass-through register captures 0 at capture-DR. A bit sampled from scanIn on a rising edge appears on scanOut at the following falling edge.
- R8: Under 0x007, the identification register loads userWord in parallel at capture-DR and then shifts it out.
- R9: A newly shifted instruction takes effect only at the rising edge that leaves the update-instruction state. Before that edge, the pin controls keep their old values.
- R10: bndCapture, bndShift and bndUpdate are asserted, each in its own data-register state, only under 0x005 and 0x00F. Under those instructions bndReturn is the serial source for scanOut.
- R11: pinMode is high under 0x00F and 0x00A. pinHighZ is high under 0x00B. Both keep their values through data scans until a new instruction is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| testClk | input | 1 | Test clock |
| testRstN | input | 1 | Asynchronous active-low controller reset |
| modeSel | input | 1 | State-steering input, sampled on the rising edge |
| scanIn | input | 1 | Serial data input, sampled on the rising edge |
| scanOut | output | 1 | Serial data output, changes on the falling edge |
| scanOutEn | output | 1 | High while scanOut carries shift data |
| bndReturn | input | 1 | Serial output of the external boundary register |
| userWord | input | 32 | Value loaded into the identification register under the user-code instruction |
| bndCapture | output | 1 | Boundary register capture strobe |
| bndShift | output | 1 | Boundary register shift strobe |
| bndUpdate | output | 1 | Boundary register update strobe |
| pinMode | output | 1 | Pins follow the boundary update flops |
| pinHighZ | output | 1 | Pins are floated |

## Verification
Suppose the state register or the held instruction goes wrong. The next data scan then returns data of the wrong length or the wrong content, and the error appears within one scan of about fifty clocks: a missing leading 0 marks a failed pass-through capture, and a corrupted leading word marks a failed identification load. A wrong decode of any one of the 1024 codes either changes the length and content of that code's data scan or moves the pin controls and boundary strobes away from their expected values. A wrong shift-enable window appears on scanOutEn at the first falling edge after entering or leaving a shift state.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

  localparam int IR_W = 10;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_RESET  = 4'hF,
    ST_IDLE   = 4'hC,
    ST_SEL_DR = 4'h7,
    ST_CAP_DR = 4'h6,
    ST_SH_DR  = 4'h2,
    ST_EX1_DR = 4'h1,
    ST_PAU_DR = 4'h3,
    ST_EX2_DR = 4'h0,
    ST_UPD_DR = 4'h5,
    ST_SEL_IR = 4'h4,
    ST_CAP_IR = 4'hE,
    ST_SH_IR  = 4'hA,
    ST_EX1_IR = 4'h9,
    ST_PAU_IR = 4'hB,
    ST_EX2_IR = 4'h8,
    ST_UPD_IR = 4'hD
  } tapState_e;

  localparam logic [IR_W-1:0] OP_SNAPSHOT = 10'h005;
  localparam logic [IR_W-1:0] OP_PINDRIVE = 10'h00F;
  localparam logic [IR_W-1:0] OP_PASS     = 10'h3FF;
  localparam logic [IR_W-1:0] OP_USERID   = 10'h007;
  localparam logic [IR_W-1:0] OP_DEVID    = 10'h006;
  localparam logic [IR_W-1:0] OP_FLOAT    = 10'h00B;
  localparam logic [IR_W-1:0] OP_HOLD     = 10'h00A;

  localparam logic [IR_W-1:0] IR_CAPTURE  = {{(IR_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BND = 2'd2
  } drPath_e;

  typedef struct packed {
    logic    capIr;
    logic    shIr;
    logic    capDr;
    logic    shDr;
    logic    updDr;
    drPath_e path;
    logic    useUser;
  } tapStrobe_t;

endpackage

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_port_pkg::*;
(
  input  logic       testClk,
  input  logic       testRstN,
  input  logic       modeSel,
  input  logic       scanIn,
  output tapStrobe_t strobe,
  output logic       irSerial,
  output logic       modeCtl,
  output logic       highzCtl
);

  tapState_e        stateQ, stateD;
  logic [IR_W-1:0]  irShift;
  logic [IR_W-1:0]  irActive;
  drPath_e          pathSel;
  logic             userSel;

  // next-state steering by modeSel
  always_comb begin
    case (stateQ)
      ST_RESET:  stateD = modeSel ? ST_RESET  : ST_IDLE;
      ST_IDLE:   stateD = modeSel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: stateD = modeSel ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: stateD = modeSel ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  stateD = modeSel ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: stateD = modeSel ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: stateD = modeSel ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: stateD = modeSel ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: stateD = modeSel ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: stateD = modeSel ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: stateD = modeSel ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  stateD = modeSel ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: stateD = modeSel ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: stateD = modeSel ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: stateD = modeSel ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: stateD = modeSel ? ST_SEL_DR : ST_IDLE;
      default:   stateD = ST_RESET;
    endcase
  end

  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN) stateQ <= ST_RESET;
    else           stateQ <= stateD;
  end

  // instruction shift stage
  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN)               irShift <= '0;
    else if (stateQ == ST_CAP_IR) irShift <= IR_CAPTURE;
    else if (stateQ == ST_SH_IR)  irShift <= {scanIn, irShift[IR_W-1:1]};
  end

  // held instruction: reloaded on entry to reset, replaced at update
  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN)                irActive <= OP_DEVID;
    else if (stateD == ST_RESET)  irActive <= OP_DEVID;
    else if (stateQ == ST_UPD_IR) irActive <= irShift;
  end

  // instruction decode
  always_comb begin
    pathSel = PATH_BYP;
    userSel = 1'b0;
    case (irActive)
      OP_DEVID:    pathSel = PATH_ID;
      OP_USERID: begin
        pathSel = PATH_ID;
        userSel = 1'b1;
      end
      OP_SNAPSHOT,
      OP_PINDRIVE: pathSel = PATH_BND;
      default:     pathSel = PATH_BYP;
    endcase
  end

  assign modeCtl  = (irActive == OP_PINDRIVE) || (irActive == OP_HOLD);
  assign highzCtl = (irActive == OP_FLOAT);
  assign irSerial = irShift[0];

  assign strobe.capIr   = (stateQ == ST_CAP_IR);
  assign strobe.shIr    = (stateQ == ST_SH_IR);
  assign strobe.capDr   = (stateQ == ST_CAP_DR);
  assign strobe.shDr    = (stateQ == ST_SH_DR);
  assign strobe.updDr   = (stateQ == ST_UPD_DR);
  assign strobe.path    = pathSel;
  assign strobe.useUser = userSel;

  // run-length of high modeSel, used only by the checks below
  logic [2:0] onesRun;
  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN)           onesRun <= '0;
    else if (!modeSel)       onesRun <= '0;
    else if (onesRun != 3'd5) onesRun <= onesRun + 3'd1;
  end

  assert_five_ones_reset_R2: assert property (@(posedge testClk) disable iff (!testRstN)
    (onesRun == 3'd5) |-> (stateQ == ST_RESET));

  assert_reset_holds_devid_R3: assert property (@(posedge testClk) disable iff (!testRstN)
    (stateQ == ST_RESET) |-> (irActive == OP_DEVID));

  assert_instr_only_at_update_R9: assert property (@(posedge testClk) disable iff (!testRstN)
    (stateQ != ST_UPD_IR) |=> ($stable(irActive) || stateQ == ST_RESET));

  assert_one_path_R6: assert property (@(posedge testClk) disable iff (!testRstN)
    $countones({pathSel == PATH_BYP, pathSel == PATH_ID, pathSel == PATH_BND}) == 1);

  assert_pin_ctl_exclusive_R11: assert property (@(posedge testClk) disable iff (!testRstN)
    !(modeCtl && highzCtl));

endmodule

// File: rtl/scan_port_dpath.sv
module scan_port_dpath
  import scan_port_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic            testClk,
  input  logic            testRstN,
  input  logic            scanIn,
  input  tapStrobe_t      strobe,
  input  logic            irSerial,
  input  logic [ID_W-1:0] userWord,
  input  logic            bndReturn,
  output logic            scanOut,
  output logic            scanOutEn
);

  logic            bypassQ;
  logic [ID_W-1:0] idShift;
  logic            serialBit;
  logic            tdoQ, tdoEnQ;

  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN) bypassQ <= 1'b0;
    else if (strobe.path == PATH_BYP) begin
      if (strobe.capDr)     bypassQ <= 1'b0;
      else if (strobe.shDr) bypassQ <= scanIn;
    end
  end

  always_ff @(posedge testClk or negedge testRstN) begin
    if (!testRstN) idShift <= ID_VALUE;
    else if (strobe.path == PATH_ID) begin
      if (strobe.capDr)     idShift <= strobe.useUser ? userWord : ID_VALUE;
      else if (strobe.shDr) idShift <= {scanIn, idShift[ID_W-1:1]};
    end
  end

  always_comb begin
    if (strobe.shIr) serialBit = irSerial;
    else begin
      case (strobe.path)
        PATH_ID:  serialBit = idShift[0];
        PATH_BND: serialBit = bndReturn;
        default:  serialBit = bypassQ;
      endcase
    end
  end

  // output side moves on the falling edge
  always_ff @(negedge testClk or negedge testRstN) begin
    if (!testRstN) begin
      tdoQ   <= 1'b0;
      tdoEnQ <= 1'b0;
    end else begin
      tdoQ   <= serialBit;
      tdoEnQ <= strobe.shIr | strobe.shDr;
    end
  end

  assign scanOut   = tdoQ;
  assign scanOutEn = tdoEnQ;

  assert_out_en_window_R4: assert property (@(posedge testClk) disable iff (!testRstN)
    scanOutEn == (strobe.shIr | strobe.shDr));

  assert_bypass_captures_zero_R7: assert property (@(posedge testClk) disable iff (!testRstN)
    (strobe.capDr && strobe.path == PATH_BYP) |=> (bypassQ == 1'b0));

  assert_devid_lsb_one_R3: assert property (@(posedge testClk) disable iff (!testRstN)
    (strobe.capDr && strobe.path == PATH_ID && !strobe.useUser) |=> idShift[0]);

  assert_user_load_R8: assert property (@(posedge testClk) disable iff (!testRstN)
    (strobe.capDr && strobe.path == PATH_ID && strobe.useUser) |=> (idShift == $past(userWord)));

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
  import scan_port_pkg::*;
#(
  parameter logic [3:0]  VERSION_ID = 4'h3,
  parameter logic [15:0] PART_ID    = 16'h2A51,
  parameter logic [10:0] MANUF_ID   = 11'h0B5
) (
  input  logic            testClk,
  input  logic            testRstN,
  input  logic            modeSel,
  input  logic            scanIn,
  output logic            scanOut,
  output logic            scanOutEn,
  input  logic            bndReturn,
  input  logic [ID_W-1:0] userWord,
  output logic            bndCapture,
  output logic            bndShift,
  output logic            bndUpdate,
  output logic            pinMode,
  output logic            pinHighZ
);

  localparam logic [ID_W-1:0] ID_VALUE = {VERSION_ID, PART_ID, MANUF_ID, 1'b1};

  tapStrobe_t strobe;
  logic       irSerial;
  logic       bndSel;

  scan_port_ctrl u_ctrl (
    .testClk  (testClk),
    .testRstN (testRstN),
    .modeSel  (modeSel),
    .scanIn   (scanIn),
    .strobe   (strobe),
    .irSerial (irSerial),
    .modeCtl  (pinMode),
    .highzCtl (pinHighZ)
  );

  scan_port_dpath #(.ID_VALUE(ID_VALUE)) u_dpath (
    .testClk   (testClk),
    .testRstN  (testRstN),
    .scanIn    (scanIn),
    .strobe    (strobe),
    .irSerial  (irSerial),
    .userWord  (userWord),
    .bndReturn (bndReturn),
    .scanOut   (scanOut),
    .scanOutEn (scanOutEn)
  );

  assign bndSel     = (strobe.path == PATH_BND);
  assign bndCapture = strobe.capDr & bndSel;
  assign bndShift   = strobe.shDr  & bndSel;
  assign bndUpdate  = strobe.updDr & bndSel;

  assert_bnd_strobes_exclusive_R10: assert property (@(posedge testClk) disable iff (!testRstN)
    $onehot0({bndCapture, bndShift, bndUpdate}));

endmodule

// File: tb/scan_port_top_tb.sv
module scan_port_top_tb;

  localparam logic [3:0]  V_ID = 4'h3;
  localparam logic [15:0] P_ID = 16'h2A51;
  localparam logic [10:0] M_ID = 11'h0B5;
  localparam logic [31:0] EXP_ID = {V_ID, P_ID, M_ID, 1'b1};
  localparam logic [7:0]  BND_CAP = 8'hA5;

  logic        testClk = 1'b0;
  logic        testRstN = 1'b0;
  logic        modeSel = 1'b1;
  logic        scanIn = 1'b0;
  logic [31:0] userWord = 32'h0;
  logic        scanOut, scanOutEn, bndReturn;
  logic        bndCapture, bndShift, bndUpdate, pinMode, pinHighZ;

  int checks = 0;
  int errors = 0;

  always #4 testClk = ~testClk;

  scan_port_top #(.VERSION_ID(V_ID), .PART_ID(P_ID), .MANUF_ID(M_ID)) u_dut (
    .testClk(testClk), .testRstN(testRstN), .modeSel(modeSel), .scanIn(scanIn),
    .scanOut(scanOut), .scanOutEn(scanOutEn), .bndReturn(bndReturn), .userWord(userWord),
    .bndCapture(bndCapture), .bndShift(bndShift), .bndUpdate(bndUpdate),
    .pinMode(pinMode), .pinHighZ(pinHighZ)
  );

  // 8-bit external boundary register model
  logic [7:0] bndModel = 8'h00;
  int capCount = 0;
  int updCount = 0;
  always @(posedge testClk) begin
    if (bndCapture)    bndModel <= BND_CAP;
    else if (bndShift) bndModel <= {scanIn, bndModel[7:1]};
    if (bndCapture) capCount <= capCount + 1;
    if (bndUpdate)  updCount <= updCount + 1;
  end
  assign bndReturn = bndModel[0];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    modeSel = m;
    scanIn  = d;
    @(posedge testClk);
    @(negedge testClk);
    #1;
  endtask

  // from idle: instruction scan, back to idle
  task automatic scanIr(input logic [9:0] din, output logic [9:0] dout);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    dout[0] = scanOut;
    for (int i = 0; i < 10; i++) begin
      step(i == 9, din[i]);
      if (i < 9) dout[i+1] = scanOut;
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // from idle: 40-bit data scan, back to idle
  task automatic scanDr(input logic [39:0] din, output logic [39:0] dout);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    dout[0] = scanOut;
    for (int i = 0; i < 40; i++) begin
      step(i == 39, din[i]);
      if (i < 39) dout[i+1] = scanOut;
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  function automatic logic [39:0] expDr(input logic [9:0] op, input logic [39:0] din,
                                        input logic [31:0] usr);
    case (op)
      10'h006:          return {din[7:0], EXP_ID};
      10'h007:          return {din[7:0], usr};
      10'h005, 10'h00F: return {din[31:0], BND_CAP};
      default:          return {din[38:0], 1'b0};
    endcase
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge testClk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [9:0]  irOut;
    logic [39:0] drOut;
    logic [39:0] din;
    int c0, u0;
    bit isBnd;

    repeat (3) @(negedge testClk);
    #1;
    check("R1 reset scanOutEn", 64'(scanOutEn), 64'd0);
    check("R11 reset pin controls", 64'({pinMode, pinHighZ}), 64'd0);
    testRstN = 1'b1;
    step(1'b0, 1'b0);

    // R3: identification after reset
    din = 40'hC3_1234_5678;
    scanDr(din, drOut);
    check("R3 id after reset", 64'(drOut), 64'({din[7:0], EXP_ID}));

    // R4: enable window walking from reset to instruction shift
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check("R4 enable low in idle", 64'(scanOutEn), 64'd0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    check("R4 enable low in capture", 64'(scanOutEn), 64'd0);
    step(1'b0, 1'b0);
    check("R4 enable high in instruction shift", 64'(scanOutEn), 64'd1);
    check("R5 first capture bit", 64'(scanOut), 64'd1);
    step(1'b0, 1'b0);
    check("R5 second capture bit", 64'(scanOut), 64'd0);
    step(1'b1, 1'b0);
    check("R4 enable low after leaving shift", 64'(scanOutEn), 64'd0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    // sweep of every instruction code
    for (int op = 0; op < 1024; op++) begin
      logic [9:0] opc;
      opc = 10'(op);
      scanIr(opc, irOut);
      check("R5 captured instruction pattern", 64'(irOut), 64'h001);
      check("R11 pin controls after update", 64'({pinMode, pinHighZ}),
            64'({(opc == 10'h00F) || (opc == 10'h00A), opc == 10'h00B}));
      userWord = {opc, ~opc, opc, 2'b01};
      din = {opc, ~opc, opc, ~opc};
      c0 = capCount;
      u0 = updCount;
      scanDr(din, drOut);
      isBnd = (opc == 10'h005) || (opc == 10'h00F);
      if (opc == 10'h007)
        check("R8 user word shifted out", 64'(drOut), 64'(expDr(opc, din, userWord)));
      else if (isBnd)
        check("R10 boundary path", 64'(drOut), 64'(expDr(opc, din, userWord)));
      else if (opc == 10'h006)
        check("R6 id path", 64'(drOut), 64'(expDr(opc, din, userWord)));
      else
        check("R7 pass-through path", 64'(drOut), 64'(expDr(opc, din, userWord)));
      check("R10 boundary capture count", 64'(capCount - c0), 64'(isBnd ? 1 : 0));
      check("R10 boundary update count", 64'(updCount - u0), 64'(isBnd ? 1 : 0));
      check("R11 pin controls held", 64'({pinMode, pinHighZ}),
            64'({(opc == 10'h00F) || (opc == 10'h00A), opc == 10'h00B}));
    end

    // R9: instruction change only at update
    scanIr(10'h00F, irOut);
    check("R9 drive instruction active", 64'(pinMode), 64'd1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(i == 9, 1'b1);
    check("R9 old instruction in exit", 64'(pinMode), 64'd1);
    step(1'b1, 1'b0);
    check("R9 old instruction in update", 64'(pinMode), 64'd1);
    step(1'b0, 1'b0);
    check("R9 new instruction after update", 64'(pinMode), 64'd0);

    // R2: five ones from data shift
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R2 in data shift", 64'(scanOutEn), 64'd1);
    repeat (5) step(1'b1, 1'b0);
    check("R2 enable low at reset", 64'(scanOutEn), 64'd0);
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    din = 40'h5A_0F0F_0F0F;
    scanDr(din, drOut);
    check("R2 reset reached, id selected", 64'(drOut), 64'({din[7:0], EXP_ID}));

    // R8: explicit user word
    scanIr(10'h007, irOut);
    userWord = 32'h1357_9BDF;
    scanDr(40'h0, drOut);
    check("R8 user word", 64'(drOut[31:0]), 64'h1357_9BDF);

    // R1: asynchronous reset mid-shift
    scanIr(10'h3FF, irOut);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R1 shifting before reset", 64'(scanOutEn), 64'd1);
    testRstN = 1'b0;
    #1;
    check("R1 async enable drop", 64'(scanOutEn), 64'd0);
    modeSel = 1'b1;
    #1;
    testRstN = 1'b1;
    @(negedge testClk);
    #1;
    step(1'b0, 1'b0);
    din = 40'hE7_AAAA_5555;
    scanDr(din, drOut);
    check("R1 id after async reset", 64'(drOut), 64'({din[7:0], EXP_ID}));

    finishRun();
  end

endmodule